// File: doc/BRIEF.md
# Processor Power Mode Controller

This block sequences a processor core between full power and two low-power states, doze and nap. Software requests a state through two bits of a mode word and a separate power-enable bit. The controller then counts down a programmable entry latency and gates the functional-unit clock. In doze, bus snooping stays alive and no handshake is needed. For nap, the controller first raises a quiesce request and waits for system logic to acknowledge it. Snooping stops as soon as that acknowledge is seen, and nap is entered after the entry countdown.

Any of the interrupt sources or a synchronous soft reset wakes the core. The return to full power takes a programmable exit latency. After a nap, the controller also waits for system logic to release the acknowledge before it turns snooping back on. An asynchronous hard reset forces full power at any time. Every pin is a plain level-sensitive control or status signal; there is no data stream. The time-base enable stays on in every state, so the time base and decrementer keep running through both low-power states.

Top module: `pmc_power_ctrl`

## Requirements
- R1: While hard reset (`rst_n` low) is asserted, the outputs are `pwr_state`=0, `qreq`=0, `snoop_en`=1, `fu_clk_en`=1 and `tb_en`=0. `tb_en` becomes 1 at the first clock edge after release and then stays 1 in every state.
- R2: `pwr_state` encodes the state as follows: 0 is full power, 1 is doze, 2 is nap and 3 is any transition. With `power_en` set, mode bit 9 alone starts a nap request and mode bit 8 alone starts a doze entry. With both bits set, nap wins. With neither bit set, `power_en` has no effect.
- R3: A low-power request is ignored in any cycle in which a wake event is present.
- R4: Doze entry shows `pwr_state`=3 for exactly ENTRY_DLY cycles and then 1. The functional-unit clock stays enabled during the countdown.
- R5: In doze, `fu_clk_en`=0, `snoop_en`=1, `tb_en`=1 and `qreq`=0.
- R6: A nap request raises `qreq` on the next cycle with snooping still on. The controller then holds `qreq` for as long as `qack` stays low.
- R7: `snoop_en` falls on the cycle after `qack` is seen. Nap (`pwr_state`=2) follows after ENTRY_DLY further cycles.
- R8: In nap, `fu_clk_en`=0, `snoop_en`=0, `qreq`=1 and `tb_en`=1.
- R9: Any of `ext_irq`, `smi_irq`, `mchk_irq`, `dec_irq` or `soft_rst` wakes the block from doze or nap. The exit shows `pwr_state`=3 with `fu_clk_en`=0 and `qreq`=0 for exactly EXIT_DLY cycles. Snooping stays on during an exit from doze.
- R10: After a nap exit, `snoop_en` stays 0 and `pwr_state` stays 3 while `qack` is high. Full power with snooping follows on the cycle after `qack` falls.
- R11: A wake event during an entry countdown aborts the entry, and this holds even in the cycle the countdown expires. A doze abort returns to full power on the next cycle. A nap abort drops `qreq` and returns to full power once `qack` is low.
- R12: Hard reset asserted in the middle of a nap clears `qreq` and reports full power without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| mode_bits | input | MODE_W | Mode word; bit 8 requests doze, bit 9 requests nap |
| power_en | input | 1 | Power-enable bit; permits a low-power entry |
| ext_irq | input | 1 | External interrupt (wake source) |
| smi_irq | input | 1 | System management interrupt (wake source) |
| mchk_irq | input | 1 | Machine check (wake source) |
| dec_irq | input | 1 | Decrementer interrupt (wake source) |
| soft_rst | input | 1 | Synchronous soft reset (wake source) |
| qack | input | 1 | Quiesce acknowledge from system logic |
| qreq | output | 1 | Quiesce request to system logic |
| snoop_en | output | 1 | Bus snoop enable |
| fu_clk_en | output | 1 | Functional-unit clock enable |
| tb_en | output | 1 | Time base / decrementer enable |
| pwr_state | output | 2 | Reported state: 0 full, 1 doze, 2 nap, 3 transition |

## Verification
Two functions can fall in the same cycle. The first pair is the end of the entry countdown and a wake event. The bench sweeps the wake pulse across every offset of the doze and nap countdowns, including the final one. It expects full power (doze) or the acknowledge-wait state (nap) on the next cycle and never the low-power code. The second pair is a low-power request and a wake event arriving together. Here the bench holds an interrupt while pulsing the request and expects the state code to stay at 0.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    ST_FULL     = 3'd0,
    ST_DOZE_ENT = 3'd1,
    ST_DOZE     = 3'd2,
    ST_NAP_REQ  = 3'd3,
    ST_NAP_ENT  = 3'd4,
    ST_NAP      = 3'd5,
    ST_WAKE     = 3'd6,
    ST_QREL     = 3'd7
  } pmc_state_e;

  typedef enum logic [1:0] {
    RPT_FULL = 2'd0,
    RPT_DOZE = 2'd1,
    RPT_NAP  = 2'd2,
    RPT_MOVE = 2'd3
  } pmc_report_e;

  typedef enum logic [1:0] {
    LP_NONE = 2'd0,
    LP_DOZE = 2'd1,
    LP_NAP  = 2'd2
  } pmc_lp_req_e;

endpackage

// File: rtl/pmc_req_decode.sv
module pmc_req_decode
  import pmc_pkg::*;
#(
  parameter int MODE_W   = 16,
  parameter int DOZE_BIT = 8,
  parameter int NAP_BIT  = 9,
  parameter int N_WAKE   = 5
) (
  input  logic [MODE_W-1:0] mode_bits,
  input  logic              power_en,
  input  logic [N_WAKE-1:0] wake_src,
  output pmc_lp_req_e       lp_req,
  output logic              wake
);

  assign wake = |wake_src;

  // Nap outranks doze when both bits are set.
  always_comb begin
    lp_req = LP_NONE;
    if (power_en) begin
      if (mode_bits[NAP_BIT])       lp_req = LP_NAP;
      else if (mode_bits[DOZE_BIT]) lp_req = LP_DOZE;
    end
  end

endmodule

// File: rtl/pmc_countdown.sv
module pmc_countdown #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // R4
  cnt_steps_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/pmc_power_ctrl.sv
module pmc_power_ctrl
  import pmc_pkg::*;
#(
  parameter int MODE_W    = 16,
  parameter int DOZE_BIT  = 8,
  parameter int NAP_BIT   = 9,
  parameter int ENTRY_DLY = 4,
  parameter int EXIT_DLY  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_bits,
  input  logic              power_en,
  input  logic              ext_irq,
  input  logic              smi_irq,
  input  logic              mchk_irq,
  input  logic              dec_irq,
  input  logic              soft_rst,
  input  logic              qack,
  output logic              qreq,
  output logic              snoop_en,
  output logic              fu_clk_en,
  output logic              tb_en,
  output logic [1:0]        pwr_state
);

  localparam int MAX_DLY = (ENTRY_DLY > EXIT_DLY) ? ENTRY_DLY : EXIT_DLY;
  localparam int CNT_W   = (MAX_DLY > 1) ? $clog2(MAX_DLY) : 1;
  localparam logic [CNT_W-1:0] ENT_LOAD = CNT_W'(ENTRY_DLY - 1);
  localparam logic [CNT_W-1:0] EXT_LOAD = CNT_W'(EXIT_DLY - 1);

  pmc_state_e       st_q, st_d;
  pmc_lp_req_e      lp_req;
  logic             wake, cnt_done, cnt_load, from_nap_q;
  logic [CNT_W-1:0] cnt_val;

  pmc_req_decode #(
    .MODE_W(MODE_W), .DOZE_BIT(DOZE_BIT), .NAP_BIT(NAP_BIT), .N_WAKE(5)
  ) u_dec (
    .mode_bits(mode_bits),
    .power_en (power_en),
    .wake_src ({soft_rst, dec_irq, mchk_irq, smi_irq, ext_irq}),
    .lp_req   (lp_req),
    .wake     (wake)
  );

  pmc_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cnt_load),
    .load_val(cnt_val),
    .done    (cnt_done)
  );

  always_comb begin
    st_d     = st_q;
    cnt_load = 1'b0;
    cnt_val  = ENT_LOAD;
    unique case (st_q)
      ST_FULL: begin
        if (!wake) begin
          if (lp_req == LP_NAP) begin
            st_d = ST_NAP_REQ;
          end else if (lp_req == LP_DOZE) begin
            st_d     = ST_DOZE_ENT;
            cnt_load = 1'b1;
          end
        end
      end
      ST_DOZE_ENT: begin
        if (wake)          st_d = ST_FULL;
        else if (cnt_done) st_d = ST_DOZE;
      end
      ST_DOZE, ST_NAP: begin
        if (wake) begin
          st_d     = ST_WAKE;
          cnt_load = 1'b1;
          cnt_val  = EXT_LOAD;
        end
      end
      ST_NAP_REQ: begin
        if (wake) begin
          st_d = qack ? ST_QREL : ST_FULL;
        end else if (qack) begin
          st_d     = ST_NAP_ENT;
          cnt_load = 1'b1;
        end
      end
      ST_NAP_ENT: begin
        if (wake)          st_d = ST_QREL;
        else if (cnt_done) st_d = ST_NAP;
      end
      ST_WAKE: begin
        if (cnt_done) st_d = from_nap_q ? ST_QREL : ST_FULL;
      end
      ST_QREL: begin
        if (!qack) st_d = ST_FULL;
      end
      default: st_d = ST_FULL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_FULL;
      from_nap_q <= 1'b0;
      tb_en      <= 1'b0;
    end else begin
      st_q  <= st_d;
      tb_en <= 1'b1;
      if (st_q == ST_NAP  && st_d == ST_WAKE) from_nap_q <= 1'b1;
      if (st_q == ST_DOZE && st_d == ST_WAKE) from_nap_q <= 1'b0;
    end
  end

  always_comb begin
    fu_clk_en = (st_q == ST_FULL) || (st_q == ST_DOZE_ENT) ||
                (st_q == ST_NAP_REQ) || (st_q == ST_NAP_ENT);
    snoop_en  = (st_q == ST_FULL) || (st_q == ST_DOZE_ENT) ||
                (st_q == ST_DOZE) || (st_q == ST_NAP_REQ) ||
                (st_q == ST_WAKE && !from_nap_q);
    qreq      = (st_q == ST_NAP_REQ) || (st_q == ST_NAP_ENT) || (st_q == ST_NAP);
    case (st_q)
      ST_FULL: pwr_state = RPT_FULL;
      ST_DOZE: pwr_state = RPT_DOZE;
      ST_NAP:  pwr_state = RPT_NAP;
      default: pwr_state = RPT_MOVE;
    endcase
  end

  // R7
  snoop_stop_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(snoop_en) |-> $past(qack));

  // R6
  qreq_rise_from_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qreq) |-> ($past(pwr_state) == RPT_FULL));

  // R11
  wake_leaves_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && (st_q == ST_DOZE_ENT || st_q == ST_NAP_ENT)) |=> (pwr_state != RPT_DOZE && pwr_state != RPT_NAP));

  // R9
  no_instant_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_state) == RPT_DOZE || $past(pwr_state) == RPT_NAP) |-> (pwr_state != RPT_FULL));

  // R10
  full_needs_ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == ST_QREL && st_q == ST_FULL) |-> !$past(qack));

  // R8
  nap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == RPT_NAP) |-> (qreq && !snoop_en && !fu_clk_en));

endmodule

// File: tb/tb_pmc_power_ctrl.sv
module tb_pmc_power_ctrl;
  localparam int E = 4;
  localparam int X = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] mode_bits = '0;
  logic power_en = 0, ext_irq = 0, smi_irq = 0, mchk_irq = 0, dec_irq = 0, soft_rst = 0, qack = 0;
  logic qreq, snoop_en, fu_clk_en, tb_en;
  logic [1:0] pwr_state;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  pmc_power_ctrl #(.ENTRY_DLY(E), .EXIT_DLY(X)) dut (
    .clk(clk), .rst_n(rst_n), .mode_bits(mode_bits), .power_en(power_en),
    .ext_irq(ext_irq), .smi_irq(smi_irq), .mchk_irq(mchk_irq), .dec_irq(dec_irq),
    .soft_rst(soft_rst), .qack(qack), .qreq(qreq), .snoop_en(snoop_en),
    .fu_clk_en(fu_clk_en), .tb_en(tb_en), .pwr_state(pwr_state));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; mode_bits = '0; power_en = 0; qack = 0;
    {ext_irq, smi_irq, mchk_irq, dec_irq, soft_rst} = '0;
    #25;
    @(negedge clk);
    rst_n = 1;
    step();
  endtask

  task automatic set_src(input int s, input logic v);
    case (s)
      0: ext_irq = v;
      1: smi_irq = v;
      2: mchk_irq = v;
      3: dec_irq = v;
      default: soft_rst = v;
    endcase
  endtask

  task automatic pulse_wake(input int s);
    set_src(s, 1'b1);
    step();
    set_src(s, 1'b0);
  endtask

  // Pulses the request; returns after the first edge.
  task automatic request(input logic [1:0] bits);
    mode_bits = '0;
    mode_bits[8] = bits[0];
    mode_bits[9] = bits[1];
    power_en = 1;
    step();
    power_en = 0;
  endtask

  // Counts steps until pwr_state equals target (one step already taken counts).
  task automatic wait_state(input logic [1:0] tgt, input int already, output int n);
    n = already;
    while (pwr_state != tgt && n < 50) begin
      step();
      n++;
    end
  endtask

  initial begin
    int n;
    #30;
    // R1 reset state
    chk(pwr_state == 0 && qreq == 0 && snoop_en == 1 && fu_clk_en == 1, "R1 reset outputs", pwr_state, 0);
    chk(tb_en == 0, "R1 tb_en in reset", tb_en, 0);
    @(negedge clk); rst_n = 1; step();
    chk(tb_en == 1, "R1 tb_en after release", tb_en, 1);

    // R2 sweep of mode bits x power_en
    for (int b = 0; b < 4; b++) begin
      for (int pe = 0; pe < 2; pe++) begin
        int exp_st, exp_q;
        do_reset();
        mode_bits = '0; mode_bits[8] = b[0]; mode_bits[9] = b[1];
        power_en = pe[0];
        step();
        power_en = 0;
        exp_st = (pe == 1 && b != 0) ? 3 : 0;
        exp_q  = (pe == 1 && b[1]) ? 1 : 0;
        chk(pwr_state == exp_st[1:0], "R2 state after request", pwr_state, exp_st);
        chk(qreq == exp_q[0], "R2 qreq after request", qreq, exp_q);
      end
    end

    // R3 request with pending wake ignored
    for (int s = 0; s < 5; s++) begin
      do_reset();
      set_src(s, 1'b1);
      request(2'b01);
      set_src(s, 1'b0);
      chk(pwr_state == 0 && fu_clk_en == 1, "R3 blocked doze", pwr_state, 0);
      set_src(s, 1'b1);
      request(2'b10);
      set_src(s, 1'b0);
      chk(pwr_state == 0 && qreq == 0, "R3 blocked nap", pwr_state, 0);
    end

    // Doze round trips with every wake source
    for (int s = 0; s < 5; s++) begin
      do_reset();
      request(2'b01);
      chk(fu_clk_en == 1 && pwr_state == 3, "R4 countdown fu on", fu_clk_en, 1);
      wait_state(2'd1, 1, n);
      chk(n == E + 1, "R4 doze entry latency", n, E + 1);
      chk(fu_clk_en == 0 && snoop_en == 1 && tb_en == 1 && qreq == 0, "R5 doze outputs", fu_clk_en, 0);
      pulse_wake(s);
      chk(pwr_state == 3 && fu_clk_en == 0 && snoop_en == 1 && qreq == 0, "R9 doze exit outputs", pwr_state, 3);
      wait_state(2'd0, 1, n);
      chk(n == X + 1, "R9 doze exit latency", n, X + 1);
    end

    // Nap round trips with every wake source
    for (int s = 0; s < 5; s++) begin
      do_reset();
      request(2'b11);
      chk(qreq == 1 && snoop_en == 1 && pwr_state == 3, "R6 nap request", qreq, 1);
      repeat (6) step();
      chk(qreq == 1 && pwr_state == 3, "R6 wait for ack", qreq, 1);
      qack = 1;
      step();
      chk(snoop_en == 0, "R7 snoop off after ack", snoop_en, 0);
      wait_state(2'd2, 1, n);
      chk(n == E + 1, "R7 nap entry latency", n, E + 1);
      chk(fu_clk_en == 0 && snoop_en == 0 && qreq == 1 && tb_en == 1, "R8 nap outputs", fu_clk_en, 0);
      pulse_wake(s);
      chk(qreq == 0 && fu_clk_en == 0 && pwr_state == 3, "R9 nap exit outputs", qreq, 0);
      repeat (X + 4) step();
      chk(pwr_state == 3 && snoop_en == 0, "R10 held while qack high", pwr_state, 3);
      qack = 0;
      step();
      chk(pwr_state == 0 && snoop_en == 1, "R10 full after qack low", pwr_state, 0);
    end

    // R11 doze abort at every countdown offset
    for (int off = 0; off < E; off++) begin
      do_reset();
      request(2'b01);
      repeat (off) step();
      pulse_wake(0);
      chk(pwr_state == 0 && fu_clk_en == 1, "R11 doze abort", pwr_state, 0);
    end

    // R11 nap abort at every countdown offset
    for (int off = 0; off < E; off++) begin
      do_reset();
      request(2'b10);
      qack = 1;
      step();
      repeat (off) step();
      pulse_wake(3);
      chk(pwr_state == 3 && qreq == 0, "R11 nap abort qreq drop", qreq, 0);
      qack = 0;
      step();
      chk(pwr_state == 0 && snoop_en == 1, "R11 nap abort full", pwr_state, 0);
    end

    // R11 abort before ack
    do_reset();
    request(2'b10);
    pulse_wake(1);
    chk(pwr_state == 0 && qreq == 0, "R11 abort before ack", pwr_state, 0);

    // R12 hard reset mid-nap
    do_reset();
    request(2'b10);
    qack = 1;
    repeat (E + 2) step();
    chk(pwr_state == 2, "R12 in nap before reset", pwr_state, 2);
    #3 rst_n = 0;
    #1;
    chk(qreq == 0 && pwr_state == 0, "R12 async clear", qreq, 0);
    qack = 0;
    @(negedge clk); rst_n = 1; step();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #3000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule